// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between an instruction byte fetcher and the execution stage of a 16-bit accumulator-style microcontroller. It takes the instruction stream one byte per cycle over a valid/ready handshake, works out from the first byte how many bytes the instruction spans, collects the operand fields, and hands one decoded record per instruction to the consumer. Instructions run from one to six bytes. Multi-byte fields arrive most-significant byte first.

The record gives the instruction length and the program counter of its first byte. It also gives the operation opcode: for an address-mode prefix this is the trailing byte, otherwise the first byte. Two operand fields follow in the order they arrive in the stream, with flags for immediate, direct and indexed addressing, a word/byte width flag, a transfer flag with its computed 16-bit target, and an illegal flag. The block keeps its own program counter. The consumer accepts a record with `recReady`, and the counter then steps by the record length. The counter can be reloaded at any time, and a reload drops any partly gathered instruction.

Top module: `instr_predecode`

## Requirements
- R1: `inReady` is high only while no record is pending and `pcLoad` is low. A pending record (`recValid` high) keeps all its fields unchanged until `recReady` is sampled high, and no input byte is taken meanwhile.
- R2: The length is decided by the first byte as follows.
  - Prefixes 0x80, 0x82 and 0xA0 take 4 bytes.
  - Prefixes 0x84, 0x86, 0xA4, 0x81, 0x83 and 0xA1 take 5 bytes.
  - Prefixes 0x85, 0x87 and 0xA5 take 6 bytes.
  - 0x8D takes 3 bytes and 0xA7 takes 5 bytes.
  - Both 0x8D and 0xA7 set the immediate flag, with the first field in `recOpndA` and the second in `recOpndB`.
- R3: Multi-byte fields are assembled most-significant byte first.
  - In a prefix, bit 2 makes the first field 16 bits wide (otherwise 8) and bit 0 makes the second field 16 bits wide (otherwise 8).
  - The trailing byte becomes `recOp`.
  - 8-bit fields are zero-extended.
- R4: In the direct prefixes (0x80–0x87, 0xA0, 0xA1, 0xA4, 0xA5), bit 1 set gives immediate=1 and direct=0, and bit 1 clear gives the reverse. Prefix 0xA2 (8-bit offset, 8-bit address, opcode; 4 bytes) and 0xA6 (16-bit offset, 8-bit address, opcode; 5 bytes) set only the indexed flag.
- R5: Bytes 0x20–0x2F are one-byte transfers to 0xFFD0 + 2 × (low nibble).
- R6: Bytes 0x30–0x37 are two-byte transfers with a 10-bit offset made of byte[1:0] (high bits) and the next byte (low bits). With byte bit 2 clear the target is PC+2+offset; with it set the target is PC−offset. The second byte appears in `recOpndA`.
- R7: 0x40 is a one-byte no-op with no transfer. 0x41–0x5F go to PC+1+low5 and 0x60–0x7F go to PC−low5, both as one-byte transfers. `recTarget` is 0 whenever `recXfer` is 0. Address arithmetic wraps modulo 2^16.
- R8: Transfers with a following byte:
  - 0x94 targets PC+2+byte and 0x95 targets PC−byte, each 2 bytes long.
  - 0xB4 and 0xB5 target PC+3+(16-bit field), 3 bytes long.
- R9: 0x90–0x93 (2 bytes, 8-bit immediate) and 0xB0–0xB3 (3 bytes, 16-bit immediate) set the immediate flag. `recOpndB` = 0x00C8 OR (byte[1:0] << 1).
- R10: `recWord` equals bit 5 of `recOp`.
- R11: Acceptance of a record advances the PC by its length. `pcLoad` sets the PC to `pcLoadVal` from the next cycle, clears any pending record and any partly gathered instruction, and holds `inReady` low in that cycle.
- R12: Bytes 0xA3, 0xCD, 0xCE, 0xED and 0xEE give a one-byte record with `recIllegal`=1 and no other mode or transfer flag. Other one-byte codes such as 0x05 are legal.
- R13: Synchronous reset clears any partial instruction and any pending record, and sets the PC to 0. After reset `inReady`=1 and `recValid`=0.
- R14: Short forms:
  - 0x98–0x9F take 2 bytes and 0xB8–0xBF take 3 bytes, both immediate.
  - 0x8C takes 3 bytes, direct, with two 8-bit fields.
  - 0x96 takes 3 bytes, direct: an 8-bit field, then the operation byte, which becomes `recOp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction byte offered |
| inByte | input | 8 | Instruction byte |
| inReady | output | 1 | Byte is taken this cycle when inValid is also high |
| pcLoad | input | 1 | Reload program counter, drop partial state |
| pcLoadVal | input | 16 | Value for program counter reload |
| recValid | output | 1 | Decoded record pending |
| recReady | input | 1 | Consumer accepts the record |
| recPc | output | 16 | Address of the record's first byte |
| recLen | output | 3 | Instruction length in bytes |
| recOp | output | 8 | Operation opcode |
| recOpndA | output | 16 | First operand field |
| recOpndB | output | 16 | Second operand field or implied register address |
| recImm | output | 1 | Source is immediate |
| recDirect | output | 1 | Direct addressing |
| recIndexed | output | 1 | Indexed addressing |
| recWord | output | 1 | Word width |
| recXfer | output | 1 | Control transfer |
| recIllegal | output | 1 | Undefined opcode |
| recTarget | output | 16 | Transfer target |

## Verification
The properties assume that reset is applied at start-up and that `pcLoad` never arrives in the cycle a record is accepted. They also assume the consumer only raises `recReady` against a valid record. The bench drives every input at the falling clock edge, issues each reload between instructions or on purpose mid-instruction, and pulses `recReady` only after it has checked a pending record. In one test a byte is held on the input while a record waits, to show that it is neither taken nor allowed to disturb the pending fields.

// File: rtl/predec_pkg.sv
package predec_pkg;

  typedef enum logic [2:0] {
    XF_NONE,
    XF_VECTOR,
    XF_CALL10,
    XF_JMP5,
    XF_JMP8,
    XF_LONG
  } xferKind_t;

  typedef struct packed {
    logic [1:0] aBytes;
    logic [1:0] bBytes;
    logic       opTail;
    logic       imm;
    logic       direct;
    logic       indexed;
    logic       illegal;
    logic       regPreset;
    xferKind_t  xfer;
  } opFormat_t;

  typedef struct packed {
    logic start;
    logic shiftA;
    logic shiftB;
    logic takeOp;
    logic advance;
    logic loadPc;
  } dpStrobe_t;

  function automatic opFormat_t classify(input logic [7:0] op);
    opFormat_t f;
    f = '0;
    f.xfer = XF_NONE;
    case (op) inside
      [8'h20:8'h2F]: f.xfer = XF_VECTOR;
      [8'h30:8'h37]: begin f.aBytes = 2'd1; f.xfer = XF_CALL10; end
      [8'h41:8'h7F]: f.xfer = XF_JMP5;
      [8'h80:8'h87], 8'hA0, 8'hA1, 8'hA4, 8'hA5: begin
        f.aBytes = op[2] ? 2'd2 : 2'd1;
        f.bBytes = op[0] ? 2'd2 : 2'd1;
        f.opTail = 1'b1;
        f.imm    = op[1];
        f.direct = ~op[1];
      end
      8'hA2, 8'hA6: begin
        f.aBytes  = op[2] ? 2'd2 : 2'd1;
        f.bBytes  = 2'd1;
        f.opTail  = 1'b1;
        f.indexed = 1'b1;
      end
      [8'h90:8'h93]: begin f.aBytes = 2'd1; f.imm = 1'b1; f.regPreset = 1'b1; end
      [8'hB0:8'hB3]: begin f.aBytes = 2'd2; f.imm = 1'b1; f.regPreset = 1'b1; end
      8'h94, 8'h95: begin f.aBytes = 2'd1; f.xfer = XF_JMP8; end
      8'hB4, 8'hB5: begin f.aBytes = 2'd2; f.xfer = XF_LONG; end
      8'h8D: begin f.aBytes = 2'd1; f.bBytes = 2'd1; f.imm = 1'b1; end
      8'hA7: begin f.aBytes = 2'd2; f.bBytes = 2'd2; f.imm = 1'b1; end
      [8'h98:8'h9F]: begin f.aBytes = 2'd1; f.imm = 1'b1; end
      [8'hB8:8'hBF]: begin f.aBytes = 2'd2; f.imm = 1'b1; end
      8'h3F, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8E,
      8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAE, 8'hAF: begin
        f.aBytes = 2'd1; f.direct = 1'b1;
      end
      8'h8C, 8'hAC: begin f.aBytes = 2'd1; f.bBytes = 2'd1; f.direct = 1'b1; end
      8'h97: begin f.aBytes = 2'd1; f.bBytes = 2'd1; f.imm = 1'b1; end
      8'hB7: begin f.aBytes = 2'd2; f.bBytes = 2'd1; f.imm = 1'b1; end
      8'h96: begin f.aBytes = 2'd1; f.opTail = 1'b1; f.direct = 1'b1; end
      8'hB6: begin f.aBytes = 2'd2; f.opTail = 1'b1; f.direct = 1'b1; end
      8'hAD: begin f.aBytes = 2'd1; f.opTail = 1'b1; end
      8'h8F: f.opTail = 1'b1;
      8'hA3, 8'hCD, 8'hCE, 8'hED, 8'hEE: f.illegal = 1'b1;
      default: f = f;
    endcase
    return f;
  endfunction

  function automatic logic [2:0] instrLen(input logic [7:0] op);
    opFormat_t f;
    f = classify(op);
    return 3'd1 + {1'b0, f.aBytes} + {1'b0, f.bBytes} + {2'b00, f.opTail};
  endfunction

  function automatic logic [1:0] fieldABytes(input logic [7:0] op);
    opFormat_t f;
    f = classify(op);
    return f.aBytes;
  endfunction

  function automatic logic [1:0] fieldBBytes(input logic [7:0] op);
    opFormat_t f;
    f = classify(op);
    return f.bBytes;
  endfunction

endpackage

// File: rtl/predec_ctrl.sv
module predec_ctrl
  import predec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       pcLoad,
  input  logic       recReady,
  output logic       inReady,
  output logic       recValid,
  output dpStrobe_t  strobe
);

  logic       holding;
  logic [2:0] pos;
  logic [2:0] need;
  logic [1:0] aCnt;
  logic [1:0] bCnt;
  logic [2:0] needIn;
  logic [2:0] sumAB;
  logic       accept;
  logic       lastByte;

  assign inReady  = ~holding & ~pcLoad;
  assign recValid = holding;
  assign accept   = inValid & inReady;
  assign needIn   = instrLen(inByte) - 3'd1;
  assign sumAB    = {1'b0, aCnt} + {1'b0, bCnt};
  assign lastByte = accept & (((pos == 3'd0) && (needIn == 3'd0)) ||
                              ((pos != 3'd0) && (pos == need)));

  always_comb begin
    strobe        = '0;
    strobe.loadPc = pcLoad;
    if (accept) begin
      if (pos == 3'd0)                strobe.start  = 1'b1;
      else if (pos <= {1'b0, aCnt})   strobe.shiftA = 1'b1;
      else if (pos <= sumAB)          strobe.shiftB = 1'b1;
      else                            strobe.takeOp = 1'b1;
    end
    if (holding && recReady && !pcLoad) strobe.advance = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || pcLoad) begin
      holding <= 1'b0;
      pos     <= 3'd0;
      need    <= 3'd0;
      aCnt    <= 2'd0;
      bCnt    <= 2'd0;
    end else if (accept) begin
      if (lastByte) begin
        holding <= 1'b1;
        pos     <= 3'd0;
      end else begin
        pos <= pos + 3'd1;
        if (pos == 3'd0) begin
          need <= needIn;
          aCnt <= fieldABytes(inByte);
          bCnt <= fieldBBytes(inByte);
        end
      end
    end else if (holding && recReady) begin
      holding <= 1'b0;
    end
  end

endmodule

// File: rtl/predec_datapath.sv
module predec_datapath
  import predec_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     VEC_BASE = 16'hFFD0,
  parameter logic [15:0]     REG_BASE = 16'h00C8,
  parameter logic [15:0]     RESET_PC = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        inByte,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] pcLoadVal,
  output logic [ADDR_W-1:0] pc,
  output logic [2:0]        len,
  output logic [7:0]        finalOp,
  output logic [15:0]       opndA,
  output logic [15:0]       opndB,
  output logic              fImm,
  output logic              fDirect,
  output logic              fIndexed,
  output logic              fWord,
  output logic              fXfer,
  output logic              fIllegal,
  output logic [ADDR_W-1:0] target
);

  localparam int FIELD_W = 16;

  logic [7:0]         firstOp;
  opFormat_t          fmt;
  logic [ADDR_W-1:0]  offs10;
  logic [ADDR_W-1:0]  offs5;
  logic [ADDR_W-1:0]  offs8;
  logic [FIELD_W-1:0] presetB;

  always_comb begin
    presetB = '0;
    if (classify(inByte).regPreset)
      presetB = REG_BASE | {13'd0, inByte[1:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      firstOp <= '0;
      finalOp <= '0;
      opndA   <= '0;
      opndB   <= '0;
      pc      <= ADDR_W'(RESET_PC);
    end else begin
      if (strobe.loadPc)       pc <= pcLoadVal;
      else if (strobe.advance) pc <= pc + ADDR_W'(len);
      if (strobe.start) begin
        firstOp <= inByte;
        finalOp <= inByte;
        opndA   <= '0;
        opndB   <= presetB;
      end
      if (strobe.shiftA) opndA   <= {opndA[7:0], inByte};
      if (strobe.shiftB) opndB   <= {opndB[7:0], inByte};
      if (strobe.takeOp) finalOp <= inByte;
    end
  end

  assign fmt      = classify(firstOp);
  assign len      = instrLen(firstOp);
  assign fImm     = fmt.imm;
  assign fDirect  = fmt.direct;
  assign fIndexed = fmt.indexed;
  assign fIllegal = fmt.illegal;
  assign fWord    = finalOp[5];
  assign fXfer    = (fmt.xfer != XF_NONE);

  assign offs10 = ADDR_W'({firstOp[1:0], opndA[7:0]});
  assign offs5  = ADDR_W'(firstOp[4:0]);
  assign offs8  = ADDR_W'(opndA[7:0]);

  always_comb begin
    case (fmt.xfer)
      XF_VECTOR: target = ADDR_W'(VEC_BASE) + ADDR_W'({firstOp[3:0], 1'b0});
      XF_CALL10: target = firstOp[2] ? (pc - offs10) : (pc + ADDR_W'(2) + offs10);
      XF_JMP5:   target = firstOp[5] ? (pc - offs5) : (pc + ADDR_W'(1) + offs5);
      XF_JMP8:   target = firstOp[0] ? (pc - offs8) : (pc + ADDR_W'(2) + offs8);
      XF_LONG:   target = pc + ADDR_W'(3) + ADDR_W'(opndA);
      default:   target = '0;
    endcase
  end

endmodule

// File: rtl/instr_predecode.sv
module instr_predecode
  import predec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  output logic              inReady,
  input  logic              pcLoad,
  input  logic [ADDR_W-1:0] pcLoadVal,
  output logic              recValid,
  input  logic              recReady,
  output logic [ADDR_W-1:0] recPc,
  output logic [2:0]        recLen,
  output logic [7:0]        recOp,
  output logic [15:0]       recOpndA,
  output logic [15:0]       recOpndB,
  output logic              recImm,
  output logic              recDirect,
  output logic              recIndexed,
  output logic              recWord,
  output logic              recXfer,
  output logic              recIllegal,
  output logic [ADDR_W-1:0] recTarget
);

  dpStrobe_t strobe;

  predec_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inByte   (inByte),
    .pcLoad   (pcLoad),
    .recReady (recReady),
    .inReady  (inReady),
    .recValid (recValid),
    .strobe   (strobe)
  );

  predec_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .inByte    (inByte),
    .strobe    (strobe),
    .pcLoadVal (pcLoadVal),
    .pc        (recPc),
    .len       (recLen),
    .finalOp   (recOp),
    .opndA     (recOpndA),
    .opndB     (recOpndB),
    .fImm      (recImm),
    .fDirect   (recDirect),
    .fIndexed  (recIndexed),
    .fWord     (recWord),
    .fXfer     (recXfer),
    .fIllegal  (recIllegal),
    .target    (recTarget)
  );

endmodule

// File: rtl/instr_predecode_chk.sv
module instr_predecode_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic              pcLoad,
  input logic [ADDR_W-1:0] pcLoadVal,
  input logic              recValid,
  input logic              recReady,
  input logic [ADDR_W-1:0] recPc,
  input logic [2:0]        recLen,
  input logic [7:0]        recOp,
  input logic [15:0]       recOpndA,
  input logic [15:0]       recOpndB,
  input logic              recXfer,
  input logic              recIllegal,
  input logic [ADDR_W-1:0] recTarget
);

  p_ready_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(inReady && recValid));

  p_hold_stable_r1: assert property (@(posedge clk) disable iff (rst)
    recValid && !recReady && !pcLoad |=>
      recValid && $stable(recOp) && $stable(recOpndA) && $stable(recOpndB) &&
      $stable(recPc) && $stable(recLen));

  p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
    recValid |-> (recLen >= 3'd1) && (recLen <= 3'd6));

  p_no_target_r7: assert property (@(posedge clk) disable iff (rst)
    recValid && !recXfer |-> recTarget == '0);

  p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
    recValid && recReady && !pcLoad |=>
      recPc == $past(recPc) + ADDR_W'($past(recLen)));

  p_load_pc_r11: assert property (@(posedge clk) disable iff (rst)
    pcLoad |=> (recPc == $past(pcLoadVal)) && !recValid);

  p_illegal_single_r12: assert property (@(posedge clk) disable iff (rst)
    recValid && recIllegal |-> (recLen == 3'd1) && !recXfer);

endmodule

bind instr_predecode instr_predecode_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inReady    (inReady),
  .pcLoad     (pcLoad),
  .pcLoadVal  (pcLoadVal),
  .recValid   (recValid),
  .recReady   (recReady),
  .recPc      (recPc),
  .recLen     (recLen),
  .recOp      (recOp),
  .recOpndA   (recOpndA),
  .recOpndB   (recOpndB),
  .recXfer    (recXfer),
  .recIllegal (recIllegal),
  .recTarget  (recTarget)
);

// File: tb/instr_predecode_bench.sv
`timescale 1ns/1ps
module instr_predecode_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inReady;
  logic        pcLoad = 1'b0;
  logic [15:0] pcLoadVal = 16'h0000;
  logic        recValid;
  logic        recReady = 1'b0;
  logic [15:0] recPc;
  logic [2:0]  recLen;
  logic [7:0]  recOp;
  logic [15:0] recOpndA;
  logic [15:0] recOpndB;
  logic        recImm, recDirect, recIndexed, recWord, recXfer, recIllegal;
  logic [15:0] recTarget;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  instr_predecode u_instr_predecode (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte), .inReady(inReady),
    .pcLoad(pcLoad), .pcLoadVal(pcLoadVal), .recValid(recValid), .recReady(recReady),
    .recPc(recPc), .recLen(recLen), .recOp(recOp), .recOpndA(recOpndA),
    .recOpndB(recOpndB), .recImm(recImm), .recDirect(recDirect),
    .recIndexed(recIndexed), .recWord(recWord), .recXfer(recXfer),
    .recIllegal(recIllegal), .recTarget(recTarget)
  );

  typedef struct packed {
    logic [15:0] pc;
    logic [47:0] bytes;
    logic [2:0]  len;
    logic [7:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [5:0]  flags;   // imm, direct, indexed, word, xfer, illegal
    logic [15:0] tgt;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{16'h1000, 48'h25_00_00_00_00_00, 3'd1, 8'h25, 16'h0000, 16'h0000, 6'b000110, 16'hFFDA, 8'd5},  // R5
    '{16'h1000, 48'h2F_00_00_00_00_00, 3'd1, 8'h2F, 16'h0000, 16'h0000, 6'b000110, 16'hFFEE, 8'd5},  // R5
    '{16'h0200, 48'h32_7F_00_00_00_00, 3'd2, 8'h32, 16'h007F, 16'h0000, 6'b000110, 16'h0481, 8'd6},  // R6
    '{16'h0800, 48'h35_10_00_00_00_00, 3'd2, 8'h35, 16'h0010, 16'h0000, 6'b000110, 16'h06F0, 8'd6},  // R6
    '{16'h0100, 48'h40_00_00_00_00_00, 3'd1, 8'h40, 16'h0000, 16'h0000, 6'b000000, 16'h0000, 8'd7},  // R7
    '{16'h0100, 48'h5F_00_00_00_00_00, 3'd1, 8'h5F, 16'h0000, 16'h0000, 6'b000010, 16'h0120, 8'd7},  // R7
    '{16'h0100, 48'h63_00_00_00_00_00, 3'd1, 8'h63, 16'h0000, 16'h0000, 6'b000110, 16'h00FD, 8'd7},  // R7
    '{16'h0010, 48'h7F_00_00_00_00_00, 3'd1, 8'h7F, 16'h0000, 16'h0000, 6'b000110, 16'hFFF1, 8'd7},  // R7 wrap
    '{16'h3000, 48'h94_20_00_00_00_00, 3'd2, 8'h94, 16'h0020, 16'h0000, 6'b000010, 16'h3022, 8'd8},  // R8
    '{16'h3000, 48'h95_FF_00_00_00_00, 3'd2, 8'h95, 16'h00FF, 16'h0000, 6'b000010, 16'h2F01, 8'd8},  // R8
    '{16'h4000, 48'hB4_12_34_00_00_00, 3'd3, 8'hB4, 16'h1234, 16'h0000, 6'b000110, 16'h5237, 8'd8},  // R8
    '{16'hFFF0, 48'hB5_00_20_00_00_00, 3'd3, 8'hB5, 16'h0020, 16'h0000, 6'b000110, 16'h0013, 8'd8},  // R8 wrap
    '{16'h0000, 48'h80_11_22_C8_00_00, 3'd4, 8'hC8, 16'h0011, 16'h0022, 6'b010000, 16'h0000, 8'd2},  // R2
    '{16'h0000, 48'h82_11_22_E8_00_00, 3'd4, 8'hE8, 16'h0011, 16'h0022, 6'b100100, 16'h0000, 8'd10}, // R10
    '{16'h0000, 48'h84_12_34_56_D8_00, 3'd5, 8'hD8, 16'h1234, 16'h0056, 6'b010000, 16'h0000, 8'd3},  // R3
    '{16'h0000, 48'h83_AB_12_34_F9_00, 3'd5, 8'hF9, 16'h00AB, 16'h1234, 6'b100100, 16'h0000, 8'd3},  // R3
    '{16'h0000, 48'h85_12_34_56_78_9C, 3'd6, 8'h9C, 16'h1234, 16'h5678, 6'b010000, 16'h0000, 8'd3},  // R3
    '{16'h0000, 48'h87_AA_BB_CC_DD_E4, 3'd6, 8'hE4, 16'hAABB, 16'hCCDD, 6'b100100, 16'h0000, 8'd4},  // R4
    '{16'h0000, 48'hA2_05_40_D0_00_00, 3'd4, 8'hD0, 16'h0005, 16'h0040, 6'b001000, 16'h0000, 8'd4},  // R4
    '{16'h0000, 48'hA6_01_02_03_F0_00, 3'd5, 8'hF0, 16'h0102, 16'h0003, 6'b001100, 16'h0000, 8'd4},  // R4
    '{16'h0000, 48'h90_5A_00_00_00_00, 3'd2, 8'h90, 16'h005A, 16'h00C8, 6'b100000, 16'h0000, 8'd9},  // R9
    '{16'h0000, 48'h93_77_00_00_00_00, 3'd2, 8'h93, 16'h0077, 16'h00CE, 6'b100000, 16'h0000, 8'd9},  // R9
    '{16'h0000, 48'hB2_BE_EF_00_00_00, 3'd3, 8'hB2, 16'hBEEF, 16'h00CC, 6'b100100, 16'h0000, 8'd9},  // R9
    '{16'h0000, 48'h8D_11_22_00_00_00, 3'd3, 8'h8D, 16'h0011, 16'h0022, 6'b100000, 16'h0000, 8'd2},  // R2
    '{16'h0000, 48'hA7_12_34_56_78_00, 3'd5, 8'hA7, 16'h1234, 16'h5678, 6'b100100, 16'h0000, 8'd2},  // R2
    '{16'h0000, 48'hA3_00_00_00_00_00, 3'd1, 8'hA3, 16'h0000, 16'h0000, 6'b000101, 16'h0000, 8'd12}, // R12
    '{16'h0000, 48'hCE_00_00_00_00_00, 3'd1, 8'hCE, 16'h0000, 16'h0000, 6'b000001, 16'h0000, 8'd12}, // R12
    '{16'h0000, 48'h05_00_00_00_00_00, 3'd1, 8'h05, 16'h0000, 16'h0000, 6'b000000, 16'h0000, 8'd12}, // R12
    '{16'h0000, 48'h98_3C_00_00_00_00, 3'd2, 8'h98, 16'h003C, 16'h0000, 6'b100000, 16'h0000, 8'd14}, // R14
    '{16'h0000, 48'hBC_12_34_00_00_00, 3'd3, 8'hBC, 16'h1234, 16'h0000, 6'b100100, 16'h0000, 8'd14}, // R14
    '{16'h0000, 48'h96_40_E8_00_00_00, 3'd3, 8'hE8, 16'h0040, 16'h0000, 6'b010100, 16'h0000, 8'd14}, // R14
    '{16'h0000, 48'h8C_10_20_00_00_00, 3'd3, 8'h8C, 16'h0010, 16'h0020, 6'b010000, 16'h0000, 8'd14}  // R14
  };

  task automatic check(input bit ok, input string req, input logic [127:0] got,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic sendByte(input logic [7:0] b);
    while (!inReady) @(negedge clk);
    inByte  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic acceptRec();
    recReady = 1'b1;
    @(negedge clk);
    recReady = 1'b0;
  endtask

  task automatic loadPc(input logic [15:0] v);
    pcLoad    = 1'b1;
    pcLoadVal = v;
    @(negedge clk);
    pcLoad = 1'b0;
  endtask

  function automatic logic [127:0] recordNow();
    return {recValid, recLen, recOp, recOpndA, recOpndB,
            recImm, recDirect, recIndexed, recWord, recXfer, recIllegal,
            recTarget, recPc};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [127:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R13: state straight after reset
    check(recValid == 1'b0 && inReady == 1'b1 && recPc == 16'h0000, "R13",
          {recValid, inReady, recPc}, {1'b0, 1'b1, 16'h0000});

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 R14
    for (int i = 0; i < NV; i++) begin
      loadPc(VECS[i].pc);
      for (int k = 0; k < int'(VECS[i].len); k++)
        sendByte(VECS[i].bytes[47 - 8*k -: 8]);
      exp = {1'b1, VECS[i].len, VECS[i].op, VECS[i].a, VECS[i].b,
             VECS[i].flags, VECS[i].tgt, VECS[i].pc};
      check(recordNow() == exp, $sformatf("R%0d vec%0d", VECS[i].req, i),
            recordNow(), exp);
      acceptRec();
    end

    // R11: PC steps by the length of each accepted record
    loadPc(16'h0100);
    sendByte(8'h84); sendByte(8'h12); sendByte(8'h34); sendByte(8'h56); sendByte(8'hD8);
    acceptRec();
    sendByte(8'h40);
    check(recPc == 16'h0105, "R11 step5", recPc, 16'h0105);
    acceptRec();
    sendByte(8'h63);
    check(recPc == 16'h0106 && recTarget == 16'h0103, "R11 step1",
          {recPc, recTarget}, {16'h0106, 16'h0103});
    acceptRec();

    // R11: reload in the middle of an instruction drops the partial bytes
    sendByte(8'h85); sendByte(8'h12);
    loadPc(16'h2000);
    sendByte(8'h40);
    check(recLen == 3'd1 && recOp == 8'h40 && recPc == 16'h2000, "R11 reload",
          {recLen, recOp, recPc}, {3'd1, 8'h40, 16'h2000});
    acceptRec();

    // R1: a pending record holds; an offered byte waits
    loadPc(16'h0500);
    sendByte(8'h40);
    inByte  = 8'h25;
    inValid = 1'b1;
    repeat (5) @(negedge clk);
    check(recValid && !inReady && recOp == 8'h40 && recPc == 16'h0500, "R1 hold",
          {recValid, inReady, recOp, recPc}, {1'b1, 1'b0, 8'h40, 16'h0500});
    recReady = 1'b1;
    @(negedge clk);
    recReady = 1'b0;
    check(inReady == 1'b1 && recValid == 1'b0, "R1 release",
          {inReady, recValid}, {1'b1, 1'b0});
    @(negedge clk);
    inValid = 1'b0;
    check(recValid && recOp == 8'h25 && recPc == 16'h0501 && recTarget == 16'hFFDA,
          "R1 next", {recValid, recOp, recPc, recTarget},
          {1'b1, 8'h25, 16'h0501, 16'hFFDA});
    acceptRec();

    // R13: reset in the middle of an instruction
    loadPc(16'h0700);
    sendByte(8'h84); sendByte(8'h12);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(recValid == 1'b0 && inReady == 1'b1, "R13 mid", {recValid, inReady}, {1'b1 ^ 1'b1, 1'b1});
    sendByte(8'h40);
    check(recLen == 3'd1 && recOp == 8'h40 && recPc == 16'h0000, "R13 restart",
          {recLen, recOp, recPc}, {3'd1, 8'h40, 16'h0000});
    acceptRec();

    summary();
  end

endmodule